// File: doc/BRIEF.md
# Parallel Display Bus Timing Engine

This block runs single accesses on an asynchronous 8080-style parallel bus towards a display module that keeps its own frame memory. It produces an active-low chip select, write strobe and read strobe, a command/data select line and a data bus with an output enable. Each edge of each strobe sits at a programmable tick count within the access. The tick counts come from two configuration words, one holding the strobe edge times and one holding the cycle lengths, the chip-select minimum width and the read sample time.

A client asks for a command write, a data (parameter) write or a read through a small request port. The request is taken only while the engine is idle, and a one-clock done pulse marks the end of the access. On a read, the bus is captured at the programmed access time and the value is held on the read-data output until the next read. A prescaler stretches each tick to one or two clock periods. A width select chooses between a 16-bit lane and an 8-bit lane, in which only the low byte is moved.

Top module: `disp_bus_engine`

## Requirements
- R1: After reset, cs_n, we_n and re_n are high, bus_oe is low, req_ready is high, done is low, dc is high and rd_data is zero.
- R2: Configuration word 0 (cfg_sel=0) packs, from the LSB upward, the chip-select assert tick [3:0] and deassert tick [9:4], the write-strobe assert [13:10] and deassert [19:14], and the read-strobe assert [23:20] and deassert [29:24]. During an access, cs_n is low for the ticks t with cs_assert <= t < cs_end, where cs_end is the larger of cs_deassert and cs_assert + cs_min_width.
- R3: On a write access, we_n is low for the ticks weon <= t < weoff and re_n stays high.
- R4: On a read access, re_n is low for the ticks reon <= t < reoff and we_n stays high.
- R5: An access lasts L ticks, where L is the larger of cs_end and the cycle length for its kind, with a minimum of 1. done is high for exactly the one clock after the last tick, and req_ready is high again in that same clock.
- R6: With div2=0 a tick is one clock. With div2=1 a tick is two clocks. Tick 0 starts in the clock after the request is accepted.
- R7: On a write, bus_oe is high for the ticks cs_assert <= t < weoff and bus_out carries the request data (low byte only, upper byte zero, when narrow=1). bus_oe stays low on reads.
- R8: A read captures bus_in at the end of the first clock of tick access_time. With narrow=1 it zero-extends bus_in[7:0]. rd_data keeps that value afterwards.
- R9: req_kind 2'b00 is a command write, 2'b01 is a data write and 2'b1x is a read. dc is driven to 0 for a command write and to 1 otherwise, from the clock after acceptance until the next accepted request.
- R10: A request presented while an access is running is ignored. No second access follows, and dc is not changed.
- R11: Configuration word 1 (cfg_sel=1) packs the write cycle length [5:0], the read cycle length [11:6], the chip-select minimum width [17:12] and the read access time [23:18].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Write strobe for a configuration word |
| cfg_sel | input | 1 | 0 selects the strobe edge word, 1 selects the cycle word |
| cfg_wdata | input | 30 | Configuration word value |
| div2 | input | 1 | Tick is two clocks when high, one clock when low |
| narrow | input | 1 | 8-bit lane when high, full lane when low |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | Access kind: 00 command write, 01 data write, 1x read |
| req_wdata | input | DW | Write data for the request |
| req_ready | output | 1 | Engine idle, request will be taken |
| done | output | 1 | One-clock pulse at end of access |
| rd_data | output | DW | Last value captured by a read |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dc | output | 1 | Command (0) or data (1) select |
| bus_out | output | DW | Data bus drive value |
| bus_oe | output | 1 | Data bus output enable |
| bus_in | input | DW | Data bus sampled value |

## Verification
The bench builds the engine with its default 16-bit lane, and uses the narrow input so that the 8-bit mode runs on the same instance. Both prescaler settings are used. The field values range up to 63 with a chip-select width of 63, so the access length reaches 78 ticks and the top of the 7-bit tick counter is used. The read value on bus_in is valid only during the one clock that should be captured, so a read that samples one clock early or late returns the wrong value.

// File: rtl/disp_bus_pkg.sv
package disp_bus_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 6;
  localparam int TW    = OFF_W + 1;
  localparam int CFG_W = 30;
  localparam int CYC_W = 4 * OFF_W;

  typedef struct packed {
    logic [OFF_W-1:0] re_off;
    logic [ON_W-1:0]  re_on;
    logic [OFF_W-1:0] we_off;
    logic [ON_W-1:0]  we_on;
    logic [OFF_W-1:0] cs_off;
    logic [ON_W-1:0]  cs_on;
  } edges_t;

  typedef struct packed {
    logic [OFF_W-1:0] acc;
    logic [OFF_W-1:0] cs_min;
    logic [OFF_W-1:0] rd_cyc;
    logic [OFF_W-1:0] wr_cyc;
  } cycle_t;

  function automatic logic [TW-1:0] max_t(logic [TW-1:0] a, logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [TW-1:0] cs_release(edges_t e, cycle_t c);
    return max_t(TW'(e.cs_off), TW'(e.cs_on) + TW'(c.cs_min));
  endfunction

  function automatic logic [TW-1:0] access_ticks(edges_t e, cycle_t c, logic rd);
    logic [TW-1:0] r;
    r = max_t(rd ? TW'(c.rd_cyc) : TW'(c.wr_cyc), cs_release(e, c));
    return (r == '0) ? TW'(1) : r;
  endfunction

  function automatic logic in_window(logic [TW-1:0] t, logic [TW-1:0] a, logic [TW-1:0] b);
    return (t >= a) && (t < b);
  endfunction
endpackage

// File: rtl/disp_bus_cfg_regs.sv
module disp_bus_cfg_regs
  import disp_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [CFG_W-1:0] wdata,
  output edges_t           edges,
  output cycle_t           cyc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges <= '0;
      cyc   <= '0;
    end else if (wr) begin
      if (sel) cyc   <= wdata[CYC_W-1:0];
      else     edges <= wdata;
    end
  end
endmodule

// File: rtl/disp_bus_prescale.sv
module disp_bus_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic div2,
  output logic tick_en,
  output logic first_clk
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= 1'b0;
    else if (start)         phase <= 1'b0;
    else if (run && div2)   phase <= ~phase;
  end

  assign tick_en   = run && (!div2 || phase);
  assign first_clk = !phase;
endmodule

// File: rtl/disp_bus_timer.sv
module disp_bus_timer
  import disp_bus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick_en,
  input  logic [TW-1:0] len,
  output logic [TW-1:0] tick,
  output logic          active,
  output logic          done
);
  logic last_tick;
  assign last_tick = active && tick_en && (tick == len - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick   <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last_tick;
      if (start) begin
        active <= 1'b1;
        tick   <= '0;
      end else if (last_tick) begin
        active <= 1'b0;
        tick   <= '0;
      end else if (active && tick_en) begin
        tick <= tick + TW'(1);
      end
    end
  end
endmodule

// File: rtl/disp_bus_engine.sv
module disp_bus_engine
  import disp_bus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             div2,
  input  logic             narrow,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic             cs_n,
  output logic             we_n,
  output logic             re_n,
  output logic             dc,
  output logic [DW-1:0]    bus_out,
  output logic             bus_oe,
  input  logic [DW-1:0]    bus_in
);
  localparam int NW = DW / 2;

  edges_t        edges;
  cycle_t        cyc;
  logic          start, active, tick_en, first_clk, is_rd;
  logic [TW-1:0] tick, len, cs_end;
  logic [DW-1:0] wdata_q;

  // named internal events for the checker
  logic          sample_now;
  logic          cs_win, we_win, re_win, oe_win;

  disp_bus_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .edges(edges), .cyc(cyc)
  );

  disp_bus_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .start(start), .run(active),
    .div2(div2), .tick_en(tick_en), .first_clk(first_clk)
  );

  disp_bus_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .tick_en(tick_en),
    .len(len), .tick(tick), .active(active), .done(done)
  );

  assign req_ready = !active;
  assign start     = req_valid && !active;
  assign cs_end    = cs_release(edges, cyc);
  assign len       = access_ticks(edges, cyc, is_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_rd   <= 1'b0;
      dc      <= 1'b1;
      wdata_q <= '0;
    end else if (start) begin
      is_rd   <= req_kind[1];
      dc      <= req_kind[1] | req_kind[0];
      wdata_q <= narrow ? {{(DW-NW){1'b0}}, req_wdata[NW-1:0]} : req_wdata;
    end
  end

  assign cs_win = in_window(tick, TW'(edges.cs_on), cs_end);
  assign we_win = in_window(tick, TW'(edges.we_on), TW'(edges.we_off));
  assign re_win = in_window(tick, TW'(edges.re_on), TW'(edges.re_off));
  assign oe_win = in_window(tick, TW'(edges.cs_on), TW'(edges.we_off));

  assign cs_n    = !(active && cs_win);
  assign we_n    = !(active && !is_rd && we_win);
  assign re_n    = !(active && is_rd && re_win);
  assign bus_oe  = active && !is_rd && oe_win;
  assign bus_out = wdata_q;

  assign sample_now = active && is_rd && first_clk && (tick == TW'(cyc.acc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_data <= '0;
    else if (sample_now) rd_data <= narrow ? {{(DW-NW){1'b0}}, bus_in[NW-1:0]} : bus_in;
  end
endmodule

// File: rtl/disp_bus_engine_chk.sv
module disp_bus_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       req_ready,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       cs_n,
  input logic       we_n,
  input logic       re_n,
  input logic       bus_oe,
  input logic       dc
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && we_n && re_n && !bus_oe));                 // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                  // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);                                              // R5
  AST_NO_WE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> we_n);                                                  // R4
  AST_NO_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !bus_oe);                                               // R7
  AST_DC_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (dc == (req_kind[1] | req_kind[0]))); // R9
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(dc));                                      // R10
endmodule

bind disp_bus_engine disp_bus_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .req_ready(req_ready),
  .req_valid(req_valid), .req_kind(req_kind), .cs_n(cs_n), .we_n(we_n),
  .re_n(re_n), .bus_oe(bus_oe), .dc(dc)
);

// File: tb/disp_bus_engine_tb_top.sv
module disp_bus_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [29:0] cfg_wdata = '0;
  logic        div2 = 1'b0, narrow = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_wdata = '0, bus_in = '0;
  logic        req_ready, done, cs_n, we_n, re_n, dc, bus_oe;
  logic [15:0] rd_data, bus_out;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  disp_bus_engine #(.DW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .div2(div2), .narrow(narrow),
    .req_valid(req_valid), .req_kind(req_kind), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rd_data(rd_data), .cs_n(cs_n),
    .we_n(we_n), .re_n(re_n), .dc(dc), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in)
  );

  typedef struct packed {
    logic [5:0] cson, csoff, weon, weoff, reon, reoff, wecyc, recyc, pw, act;
    logic [1:0] kind;
    logic       d2, nar;
    logic [15:0] wd, rv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{6'd0, 6'd6,  6'd1, 6'd4, 6'd0, 6'd1,  6'd8,  6'd5,  6'd2,  6'd2,  2'b00, 1'b0, 1'b0, 16'hA5C3, 16'h0000},
    '{6'd1, 6'd5,  6'd2, 6'd4, 6'd1, 6'd2,  6'd3,  6'd3,  6'd7,  6'd1,  2'b01, 1'b1, 1'b1, 16'h1234, 16'h0000},
    '{6'd0, 6'd7,  6'd0, 6'd1, 6'd1, 6'd6,  6'd2,  6'd9,  6'd1,  6'd3,  2'b10, 1'b0, 1'b0, 16'h0000, 16'hBEEF},
    '{6'd2, 6'd9,  6'd0, 6'd1, 6'd3, 6'd8,  6'd2,  6'd4,  6'd0,  6'd5,  2'b11, 1'b1, 1'b1, 16'h0000, 16'h7E81},
    '{6'd0, 6'd10, 6'd2, 6'd9, 6'd0, 6'd1,  6'd4,  6'd2,  6'd1,  6'd1,  2'b01, 1'b0, 1'b0, 16'hFFFF, 16'h0000},
    '{6'd15,6'd63, 6'd0, 6'd1, 6'd14,6'd60, 6'd2,  6'd40, 6'd63, 6'd30, 2'b10, 1'b1, 1'b0, 16'h0000, 16'hC35A}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic program_cfg(input vec_t v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0;
    cfg_wdata = {v.reoff, v.reon[3:0], v.weoff, v.weon[3:0], v.csoff, v.cson[3:0]};
    @(negedge clk);
    cfg_sel = 1'b1;
    cfg_wdata = {6'd0, v.act, v.pw, v.recyc, v.wecyc};
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    bit rd;
    int csend, len, dv, c0, t, last;
    bit e_cs, e_we, e_re, e_oe, e_done, e_act;
    bit bad_cs, bad_we, bad_re, bad_oe, bad_done, bad_dc;
    int ac_cs, ac_we, ac_re, ac_oe, ac_done, ac_dc;
    logic [15:0] exp_wd, exp_rd;
    rd    = v.kind[1];
    csend = imax(int'(v.csoff), int'(v.cson) + int'(v.pw));
    len   = imax(rd ? int'(v.recyc) : int'(v.wecyc), csend);
    if (len == 0) len = 1;
    dv    = v.d2 ? 2 : 1;
    c0    = int'(v.act) * dv;
    last  = len * dv;
    exp_wd = v.nar ? {8'h00, v.wd[7:0]} : v.wd;
    exp_rd = v.nar ? {8'h00, v.rv[7:0]} : v.rv;
    bad_cs = 0; bad_we = 0; bad_re = 0; bad_oe = 0; bad_done = 0; bad_dc = 0;
    ac_cs = 0; ac_we = 0; ac_re = 0; ac_oe = 0; ac_done = 0; ac_dc = 0;
    program_cfg(v);
    div2 = v.d2; narrow = v.nar; bus_in = ~v.rv;
    req_valid = 1'b1; req_kind = v.kind; req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c <= last + 2; c++) begin
      if (c == c0)     bus_in = v.rv;
      if (c == c0 + 1) bus_in = ~v.rv;
      t      = c / dv;
      e_act  = (c < last);
      e_cs   = e_act && t >= int'(v.cson) && t < csend;
      e_we   = e_act && !rd && t >= int'(v.weon) && t < int'(v.weoff);
      e_re   = e_act && rd && t >= int'(v.reon) && t < int'(v.reoff);
      e_oe   = e_act && !rd && t >= int'(v.cson) && t < int'(v.weoff);
      e_done = (c == last);
      if (cs_n !== !e_cs && !bad_cs) begin bad_cs = 1; ac_cs = c; end
      if (we_n !== !e_we && !bad_we) begin bad_we = 1; ac_we = c; end
      if (re_n !== !e_re && !bad_re) begin bad_re = 1; ac_re = c; end
      if ((bus_oe !== e_oe || (e_oe && bus_out !== exp_wd)) && !bad_oe) begin
        bad_oe = 1; ac_oe = c;
      end
      if ((done !== e_done || req_ready !== !e_act) && !bad_done) begin
        bad_done = 1; ac_done = c;
      end
      if (dc !== (v.kind != 2'b00) && !bad_dc) begin bad_dc = 1; ac_dc = c; end
      @(negedge clk);
    end
    check(!bad_cs,   "R2",         $sformatf("vec%0d cs_n window, first bad cycle", idx), ac_cs, -1);
    check(!bad_we,   "R3",         $sformatf("vec%0d we_n window, first bad cycle", idx), ac_we, -1);
    check(!bad_re,   "R4",         $sformatf("vec%0d re_n window, first bad cycle", idx), ac_re, -1);
    check(!bad_oe,   "R7",         $sformatf("vec%0d bus_oe/bus_out, first bad cycle", idx), ac_oe, -1);
    check(!bad_done, "R5 R6 R11",  $sformatf("vec%0d done/ready timing, first bad cycle", idx), ac_done, -1);
    check(!bad_dc,   "R9",         $sformatf("vec%0d dc level, first bad cycle", idx), ac_dc, -1);
    if (rd)
      check(rd_data === exp_rd, "R8", $sformatf("vec%0d rd_data", idx), rd_data, exp_rd);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n === 1'b1 && we_n === 1'b1 && re_n === 1'b1, "R1", "strobes idle", {cs_n, we_n, re_n}, 3'b111);
    check(bus_oe === 1'b0 && done === 1'b0, "R1", "oe/done low", {bus_oe, done}, 0);
    check(req_ready === 1'b1 && dc === 1'b1 && rd_data === 16'h0, "R1", "ready/dc/rd_data",
          {req_ready, dc, rd_data}, {2'b11, 16'h0});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    // R10: a request while busy is ignored
    program_cfg(VECS[0]);
    div2 = 1'b0; narrow = 1'b0;
    req_valid = 1'b1; req_kind = 2'b00; req_wdata = 16'h0101;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b01;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    begin
      bit second;
      second = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (cs_n !== 1'b1 || req_ready !== 1'b1) second = 1;
      end
      check(!second, "R10", "no access after busy request", second, 0);
      check(dc === 1'b0, "R10", "dc kept from command write", dc, 0);
    end

    finish_run();
  end
endmodule